// File: doc/BRIEF.md
# Dual Clock Frequency Comparator

The block checks whether a clock under test runs at the expected rate compared with a reference clock. Both clocks are picked from a small set of input clocks through select registers. When a comparison starts, a reference-domain counter counts down a main count and then a tolerance window count. At the same time a test-domain counter counts down its own seed. The test counter expires and the expiry event crosses into the reference domain. The result is decided by where the reference counters stand at that moment.

If the expiry arrives while the main count is still running, the test clock is too fast. If the expiry has not arrived by the end of the window, the test clock is too slow or missing. If it arrives inside the window, the measurement passes. A bus-clock watchdog reports a reference clock that has stopped. A comparison runs once, or in continuous mode it reloads and repeats after every pass. The results are latched in write-one-to-clear status flags and are driven out on separately enabled done and error outputs. The live counter values stay readable after a decision, so software can tell which failure occurred.

Top module: `dcmp_top`

## Requirements
- R1: After reset, status (0x14) reads 0, control (0x00) reads 0, both source selects (0x24 test, 0x28 reference) read 0x0000A000, and done_o and err_o are low.
- R2: The seeds are written and read back at 0x08 (main reference count), 0x0C (window count) and 0x10 (test count).
- R3: When the test count expires after the main count has reached zero and while the window count is nonzero, status bit 1 (done) sets and bit 0 stays clear. The main counter then reads 0 and the window counter reads nonzero.
- R4: When the test count expires while the main count is nonzero, status bit 0 (error) sets. The live test counter (0x20) then reads 0 and the live main counter (0x18) reads nonzero.
- R5: When the main and window counts both reach zero before the test count expires, status bit 0 sets. The live main (0x18) and window (0x1C) counters then read 0 and the live test counter reads nonzero.
- R6: A missing test clock ends in the error flag. A reference clock that gives no edge for WD_LIM bus cycles during a comparison sets the error flag and halts the comparison.
- R7: done_o follows the done flag only while control bits 15:12 equal 0xA. err_o follows the error flag only while control bits 7:4 equal 0xA.
- R8: When control bits 11:8 equal 0x5, the comparison reloads all seeds after a pass and runs again. With any other code it runs once and then holds its counters.
- R9: A select register takes a write only when bits 15:12 equal 0xA. The low bits hold the source index. Other writes leave it unchanged.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: A comparison runs only while control bits 3:0 equal 0xA. Any other code starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset (all domains) |
| src_clk | input | NSRC | Candidate clocks for reference and test |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| done_o | output | 1 | Pass indication, gated by its enable |
| err_o | output | 1 | Failure indication, gated by its enable |

## Verification
The assertions assume that the seeds, the mode and the source selects stay fixed while a comparison runs. They also assume that the live counters are read only after a decision, because those values cross domains without a handshake. The bench changes a select or a seed only after writing a non-running start code and leaving a gap for both domains to go idle. It chooses seeds so that every expected expiry lands many reference cycles away from a window edge, which keeps the synchronizer latency from deciding any outcome.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
  localparam logic [3:0] KEY_ON   = 4'hA;
  localparam logic [3:0] KEY_CONT = 4'h5;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_SEED0 = 8'h08;
  localparam logic [7:0] A_SEEDV = 8'h0C;
  localparam logic [7:0] A_SEED1 = 8'h10;
  localparam logic [7:0] A_STAT  = 8'h14;
  localparam logic [7:0] A_LIVE0 = 8'h18;
  localparam logic [7:0] A_LIVEV = 8'h1C;
  localparam logic [7:0] A_LIVE1 = 8'h20;
  localparam logic [7:0] A_SELT  = 8'h24;
  localparam logic [7:0] A_SELR  = 8'h28;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} cmp_st_t;
endpackage

// File: rtl/dcmp_sync.sv
module dcmp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/dcmp_tst_ctr.sv
module dcmp_tst_ctr #(
  parameter int C1W = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           arm_a,
  input  logic [C1W-1:0] seed,
  output logic           expd,
  output logic [C1W-1:0] cnt
);
  logic arm_s;
  logic loaded;

  dcmp_sync #(.W(1)) u_arm_sync (.clk(clk), .rst(rst), .d(arm_a), .q(arm_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      expd   <= 1'b0;
      loaded <= 1'b0;
    end else if (!arm_s) begin
      expd   <= 1'b0;
      loaded <= 1'b0;
    end else if (!loaded) begin
      cnt    <= seed;
      loaded <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      expd <= 1'b1;
    end
  end

  // R5 / R8: once disarmed the test count holds for diagnosis
  assert_cnt1_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !arm_s |=> $stable(cnt));
endmodule

// File: rtl/dcmp_ref_ctl.sv
module dcmp_ref_ctl
  import dcmp_pkg::*;
#(
  parameter int C0W = 20,
  parameter int CVW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go_a,
  input  logic           cont,
  input  logic [C0W-1:0] seed0,
  input  logic [CVW-1:0] seedv,
  input  logic           exp_a,
  output logic           arm,
  output logic           done_t,
  output logic           err_t,
  output logic           hb,
  output logic [C0W-1:0] cnt0,
  output logic [CVW-1:0] cntv
);
  cmp_st_t    st;
  logic [1:0] syn;
  logic       go_s, exp_s, pass;

  dcmp_sync #(.W(2)) u_sync (.clk(clk), .rst(rst), .d({go_a, exp_a}), .q(syn));
  assign go_s  = syn[1];
  assign exp_s = syn[0];
  assign pass  = (cnt0 == '0) && (cntv != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      arm    <= 1'b0;
      done_t <= 1'b0;
      err_t  <= 1'b0;
      hb     <= 1'b0;
      cnt0   <= '0;
      cntv   <= '0;
    end else begin
      hb <= ~hb;
      case (st)
        ST_IDLE: if (go_s && !exp_s) begin
          cnt0 <= seed0;
          cntv <= seedv;
          arm  <= 1'b1;
          st   <= ST_RUN;
        end
        ST_RUN: begin
          if (!go_s) begin
            arm <= 1'b0;
            st  <= ST_IDLE;
          end else if (exp_s) begin
            arm <= 1'b0;
            if (pass) begin
              done_t <= ~done_t;
              st     <= cont ? ST_IDLE : ST_HALT;
            end else begin
              err_t <= ~err_t;
              st    <= ST_HALT;
            end
          end else if (cnt0 == '0 && cntv == '0) begin
            arm   <= 1'b0;
            err_t <= ~err_t;
            st    <= ST_HALT;
          end else if (cnt0 != '0) begin
            cnt0 <= cnt0 - 1'b1;
          end else begin
            cntv <= cntv - 1'b1;
          end
        end
        ST_HALT: if (!go_s) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_pass_done_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && go_s && exp_s && cnt0 == '0 && cntv != '0) |=> (done_t != $past(done_t)));

  assert_fast_err_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && go_s && exp_s && cnt0 != '0) |=> (err_t != $past(err_t)));

  assert_slow_err_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && go_s && !exp_s && cnt0 == '0 && cntv == '0) |=> (err_t != $past(err_t)));

  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HALT) |=> ($stable(cnt0) && $stable(cntv)));
endmodule

// File: rtl/dcmp_regs.sv
module dcmp_regs
  import dcmp_pkg::*;
#(
  parameter int C0W    = 20,
  parameter int CVW    = 16,
  parameter int C1W    = 20,
  parameter int SW     = 2,
  parameter int WD_LIM = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [7:0]     addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic           go,
  output logic           cont,
  output logic [C0W-1:0] sd0,
  output logic [CVW-1:0] sdv,
  output logic [C1W-1:0] sd1,
  output logic [SW-1:0]  selt,
  output logic [SW-1:0]  selr,
  input  logic           done_t,
  input  logic           err_t,
  input  logic           hb,
  input  logic [C0W-1:0] live0,
  input  logic [CVW-1:0] livev,
  input  logic [C1W-1:0] live1,
  output logic           done_o,
  output logic           err_o
);
  localparam int WDW = $clog2(WD_LIM + 1);
  localparam logic [WDW-1:0] WD_MAX = WDW'(WD_LIM);

  logic [15:0]    ctrl;
  logic [1:0]     stat, stat_n, w1c;
  logic [2:0]     syn, prev;
  logic           wd_halt, hb_chg, wd_fire, done_en, err_en;
  logic [WDW-1:0] wd_cnt;
  logic           unused_wd;

  dcmp_sync #(.W(3)) u_sync (.clk(clk), .rst(rst), .d({hb, err_t, done_t}), .q(syn));

  assign unused_wd = ^wdata;
  assign done_en   = (ctrl[15:12] == KEY_ON);
  assign err_en    = (ctrl[7:4] == KEY_ON);
  assign cont      = (ctrl[11:8] == KEY_CONT);
  assign go        = (ctrl[3:0] == KEY_ON) && !wd_halt;
  assign hb_chg    = syn[2] ^ prev[2];
  assign wd_fire   = go && !hb_chg && (wd_cnt == WD_MAX);
  assign w1c       = (wr_en && addr == A_STAT) ? wdata[1:0] : 2'b00;
  assign stat_n    = (stat & ~w1c) | {syn[0] ^ prev[0], (syn[1] ^ prev[1]) | wd_fire};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      sd0     <= '0;
      sdv     <= '0;
      sd1     <= '0;
      selt    <= '0;
      selr    <= '0;
      stat    <= '0;
      prev    <= '0;
      wd_halt <= 1'b0;
      wd_cnt  <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rdata   <= '0;
    end else begin
      prev   <= syn;
      stat   <= stat_n;
      done_o <= stat[1] && done_en;
      err_o  <= stat[0] && err_en;
      if (!go || hb_chg)         wd_cnt <= '0;
      else if (wd_cnt != WD_MAX) wd_cnt <= wd_cnt + 1'b1;
      if (wd_fire) wd_halt <= 1'b1;
      if (wr_en) begin
        case (addr)
          A_CTRL: begin
            ctrl    <= wdata[15:0];
            wd_halt <= 1'b0;
          end
          A_SEED0: sd0 <= wdata[C0W-1:0];
          A_SEEDV: sdv <= wdata[CVW-1:0];
          A_SEED1: sd1 <= wdata[C1W-1:0];
          A_SELT:  if (wdata[15:12] == KEY_ON) selt <= wdata[SW-1:0];
          A_SELR:  if (wdata[15:12] == KEY_ON) selr <= wdata[SW-1:0];
          default: ;
        endcase
      end
      if (rd_en) begin
        case (addr)
          A_CTRL:  rdata <= {16'h0, ctrl};
          A_SEED0: rdata <= 32'(sd0);
          A_SEEDV: rdata <= 32'(sdv);
          A_SEED1: rdata <= 32'(sd1);
          A_STAT:  rdata <= {30'h0, stat};
          A_LIVE0: rdata <= 32'(live0);
          A_LIVEV: rdata <= 32'(livev);
          A_LIVE1: rdata <= 32'(live1);
          A_SELT:  rdata <= {16'h0, KEY_ON, {(12-SW){1'b0}}, selt};
          A_SELR:  rdata <= {16'h0, KEY_ON, {(12-SW){1'b0}}, selr};
          default: rdata <= '0;
        endcase
      end
    end
  end

  assert_sel_key_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SELT && wdata[15:12] != KEY_ON) |=> $stable(selt));

  assert_err_gate_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(err_en));

  assert_done_gate_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(done_en));

  assert_w1c_done_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_STAT && wdata[1] && !(syn[0] ^ prev[0])) |=> !stat[1]);

  assert_wd_err_R6: assert property (@(posedge clk) disable iff (rst)
    (go && !hb_chg && wd_cnt == WD_MAX) |=> (stat[0] && !go));
endmodule

// File: rtl/dcmp_top.sv
module dcmp_top #(
  parameter int NSRC   = 4,
  parameter int C0W    = 20,
  parameter int CVW    = 16,
  parameter int C1W    = 20,
  parameter int WD_LIM = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_clk,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [7:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            done_o,
  output logic            err_o
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic           go, cont, arm, expd, done_t, err_t, hb;
  logic           clk_ref, clk_tst;
  logic [SW-1:0]  selt, selr;
  logic [C0W-1:0] sd0, live0;
  logic [CVW-1:0] sdv, livev;
  logic [C1W-1:0] sd1, live1;

  assign clk_ref = src_clk[selr];
  assign clk_tst = src_clk[selt];

  dcmp_regs #(.C0W(C0W), .CVW(CVW), .C1W(C1W), .SW(SW), .WD_LIM(WD_LIM)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .go(go), .cont(cont), .sd0(sd0), .sdv(sdv), .sd1(sd1),
    .selt(selt), .selr(selr), .done_t(done_t), .err_t(err_t), .hb(hb),
    .live0(live0), .livev(livev), .live1(live1), .done_o(done_o), .err_o(err_o));

  dcmp_ref_ctl #(.C0W(C0W), .CVW(CVW)) u_ref (
    .clk(clk_ref), .rst(rst), .go_a(go), .cont(cont), .seed0(sd0), .seedv(sdv),
    .exp_a(expd), .arm(arm), .done_t(done_t), .err_t(err_t), .hb(hb),
    .cnt0(live0), .cntv(livev));

  dcmp_tst_ctr #(.C1W(C1W)) u_tst (
    .clk(clk_tst), .rst(rst), .arm_a(arm), .seed(sd1), .expd(expd), .cnt(live1));
endmodule

// File: tb/dcmp_top_tb.sv
module dcmp_top_tb;
  import dcmp_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_clk = 4'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        done_o, err_o;

  int checks = 0, failures = 0;
  logic chk_now = 1'b0, chk_d = 1'b0;

  typedef struct { logic [7:0] a; logic [31:0] v; bit nz; string tag; } item_t;
  item_t sb[$];

  always #4  clk = ~clk;
  always #5  src_clk[0] = ~src_clk[0];
  always #10 src_clk[1] = ~src_clk[1];
  always #20 src_clk[2] = ~src_clk[2];

  dcmp_top u_dut (.clk(clk), .rst(rst), .src_clk(src_clk), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .done_o(done_o), .err_o(err_o));

  always @(posedge clk) chk_d <= rd_en && chk_now;

  // monitor: compares each checked read against the head of the scoreboard
  always @(negedge clk) begin
    item_t it;
    if (chk_d) begin
      it = sb.pop_front();
      checks++;
      if (it.nz ? (rdata == 32'h0) : (rdata !== it.v)) begin
        failures++;
        $display("FAIL %s addr=%02h actual=%08h expected=%s%08h", it.tag, it.a, rdata,
                 it.nz ? "nonzero/" : "", it.v);
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input bit chk, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; chk_now = chk;
    @(negedge clk); rd_en = 1'b0; chk_now = 1'b0; d = rdata;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] v, input bit nz, input string tag);
    logic [31:0] d;
    sb.push_back('{a: a, v: v, nz: nz, tag: tag});
    bus_rd(a, 1'b1, d);
  endtask

  task automatic chk_sig(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wait_stat();
    logic [31:0] d;
    for (int i = 0; i < 300; i++) begin
      bus_rd(A_STAT, 1'b0, d);
      if (d != 0) break;
      repeat (8) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic stop_run();
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_STAT, 32'h3);
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    expect_rd(A_STAT, 32'h0, 0, "R1 status");
    expect_rd(A_CTRL, 32'h0, 0, "R1 ctrl");
    expect_rd(A_SELT, 32'hA000, 0, "R1 sel test");
    expect_rd(A_SELR, 32'hA000, 0, "R1 sel ref");
    chk_sig(done_o, 1'b0, "R1 done_o");
    chk_sig(err_o, 1'b0, "R1 err_o");

    // R2 seeds
    bus_wr(A_SEED0, 180); bus_wr(A_SEEDV, 60); bus_wr(A_SEED1, 100);
    expect_rd(A_SEED0, 180, 0, "R2 seed0");
    expect_rd(A_SEEDV, 60, 0, "R2 seedv");
    expect_rd(A_SEED1, 100, 0, "R2 seed1");

    // R9 keyed select
    bus_wr(A_SELT, 32'hA001);
    bus_wr(A_SELT, 32'h5002);
    expect_rd(A_SELT, 32'hA001, 0, "R9 sel bad key ignored");

    // R11 wrong start code
    bus_wr(A_CTRL, 32'hAAA5);
    repeat (600) @(negedge clk);
    expect_rd(A_STAT, 32'h0, 0, "R11 no run on start code 5");
    stop_run();

    // R3 pass, single shot
    bus_wr(A_CTRL, 32'hAAAA);
    wait_stat();
    expect_rd(A_STAT, 32'h2, 0, "R3 done flag");
    chk_sig(done_o, 1'b1, "R3 done_o");
    chk_sig(err_o, 1'b0, "R3 err_o");
    expect_rd(A_LIVE0, 32'h0, 0, "R3 live main zero");
    expect_rd(A_LIVEV, 32'h0, 1, "R3 live window running");
    // R10 write-one-to-clear, then R8 single shot does not repeat
    bus_wr(A_STAT, 32'h1);
    expect_rd(A_STAT, 32'h2, 0, "R10 write 1 to other bit keeps done");
    bus_wr(A_STAT, 32'h2);
    expect_rd(A_STAT, 32'h0, 0, "R10 done cleared");
    repeat (800) @(negedge clk);
    expect_rd(A_STAT, 32'h0, 0, "R8 single shot stays stopped");
    stop_run();

    // R4 fast test clock
    bus_wr(A_SEED1, 50);
    bus_wr(A_CTRL, 32'hAAAA);
    wait_stat();
    expect_rd(A_STAT, 32'h1, 0, "R4 error flag");
    chk_sig(err_o, 1'b1, "R4 err_o");
    expect_rd(A_LIVE1, 32'h0, 0, "R4 live test zero");
    expect_rd(A_LIVE0, 32'h0, 1, "R4 live main nonzero");
    stop_run();

    // R7 error output gated off
    bus_wr(A_CTRL, 32'hAA0A);
    wait_stat();
    expect_rd(A_STAT, 32'h1, 0, "R7 error flag w/o enable");
    chk_sig(err_o, 1'b0, "R7 err_o gated");
    stop_run();

    // R5 slow test clock
    bus_wr(A_SEED1, 200);
    bus_wr(A_CTRL, 32'hAAAA);
    wait_stat();
    expect_rd(A_STAT, 32'h1, 0, "R5 error flag");
    expect_rd(A_LIVE0, 32'h0, 0, "R5 live main zero");
    expect_rd(A_LIVEV, 32'h0, 0, "R5 live window zero");
    expect_rd(A_LIVE1, 32'h0, 1, "R5 live test nonzero");
    stop_run();

    // R7 done output gated off
    bus_wr(A_SEED1, 100);
    bus_wr(A_CTRL, 32'h0AAA);
    wait_stat();
    expect_rd(A_STAT, 32'h2, 0, "R7 done flag w/o enable");
    chk_sig(done_o, 1'b0, "R7 done_o gated");
    stop_run();

    // R6 missing test clock
    bus_wr(A_SELT, 32'hA003);
    bus_wr(A_CTRL, 32'hAAAA);
    wait_stat();
    expect_rd(A_STAT, 32'h1, 0, "R6 missing test clock");
    stop_run();
    bus_wr(A_SELT, 32'hA001);

    // R6 missing reference clock
    bus_wr(A_SELR, 32'hA003);
    repeat (10) @(negedge clk);
    bus_wr(A_CTRL, 32'hAAAA);
    wait_stat();
    expect_rd(A_STAT, 32'h1, 0, "R6 missing reference clock");
    chk_sig(err_o, 1'b1, "R6 err_o");
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_SELR, 32'hA000);
    bus_wr(A_STAT, 32'h3);
    repeat (60) @(negedge clk);

    // R8 continuous mode repeats
    bus_wr(A_CTRL, 32'hA5AA);
    wait_stat();
    expect_rd(A_STAT, 32'h2, 0, "R8 continuous first pass");
    bus_wr(A_STAT, 32'h2);
    wait_stat();
    expect_rd(A_STAT, 32'h2, 0, "R8 continuous repeat pass");
    stop_run();

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule